// File: doc/BRIEF.md
# Output Driver Enable and Protection Supervisor

This block decides, cycle by cycle, whether the power-stage output drivers of a class-D amplifier may switch. It sequences a timed soft start when the chip-enable input goes high. It runs a timed shutdown when chip-enable drops, and it cuts the drivers on any of three faults. Those faults are junction over-temperature, a sustained overcurrent on any driver, and a supply below the brown-out threshold. Each fault has its own recovery rule, and the drivers return only once every active fault has cleared.

All intervals are counted in pulses of `tick_i`. The system supplies a slow strobe so that millisecond and microsecond windows can be shrunk in simulation. A separate synchronous power-on-reset input stands for a deep supply collapse. It returns the whole block to the powered-down state and clears the sticky fault flags.

Top module: `drvsup_top`

## Requirements
- R1: After `rst_ni` low or a cycle with `por_i` high, `drv_en_o`=0, `mute_o`=1, `active_o`=0 and all three fault flags are 0, whatever `en_i` is. With `en_i` high after `por_i` falls, power-up restarts.
- R2: With `en_i` high from the powered-down state, `active_o` rises on the next clock. `mute_o` stays 1 and `drv_en_o` stays 0 for T_PWRUP-1 ticks. On the T_PWRUP-th tick `drv_en_o` goes 1 and `mute_o` goes 0.
- R3: When `en_i` falls, `drv_en_o` goes 0 and `mute_o` goes 1 at the next clock. `active_o` stays 1 until the T_PWRDN-th tick and then goes 0.
- R4: `ot_i` high forces `drv_en_o` to 0 in the same cycle and sets `flt_thermal_o`.
- R5: After `ot_i` falls, the drivers return only after `cool_i` has been high for T_COOL ticks without a break. While `ot_i` is high, no recovery happens. Any cycle with `cool_i` low restarts the window.
- R6: An overcurrent on any bit of `oc_i`, held for T_SC_QUAL ticks while the drivers are sequenced on, trips the drivers off and sets `flt_short_o`. A shorter pulse has no effect. While the sequence is not on, overcurrent is not counted.
- R7: After a trip, the drivers stay off for T_SC_OFF ticks and then return. Overcurrent during the off window is ignored. A persisting short trips again after T_SC_QUAL ticks, and this cycle repeats until the short clears.
- R8: `uv_i` high forces `drv_en_o` to 0 in the same cycle and sets `flt_uv_o`. The power sequence keeps its state (`active_o`=1, `mute_o`=0), and the drivers return as soon as `uv_i` clears.
- R9: With several faults active at once, `drv_en_o` stays 0 until every one of them has cleared.
- R10: Fault flags stay set after their cause clears, until `rst_ni` or `por_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Timebase strobe, one cycle per tick |
| en_i | input | 1 | Chip enable level |
| por_i | input | 1 | Deep-undervoltage power-on reset, synchronous |
| ot_i | input | 1 | Over-temperature comparator |
| cool_i | input | 1 | Below-recovery-temperature comparator |
| oc_i | input | N_DRV | Per-driver overcurrent flags |
| uv_i | input | 1 | Supply below brown-out level |
| drv_en_o | output | 1 | Output drivers enabled |
| mute_o | output | 1 | Soft-start / mute, high unless sequenced on |
| active_o | output | 1 | Analog section powered (not in powered-down state) |
| flt_thermal_o | output | 1 | Sticky thermal shutdown flag |
| flt_short_o | output | 1 | Sticky short-circuit trip flag |
| flt_uv_o | output | 1 | Sticky brown-out flag |

## Verification
The bench sweeps every overcurrent pulse length below the qualification window on each driver bit. A design that counted one tick too few, or watched only one driver, would trip early or miss a short. It also breaks the cool-down window after every possible tick count, which catches a recovery counter that is not cleared by a momentary warm reading. A persistent short is held across several retry periods, and a late recovery window would show up there. The bench then stacks faults to catch a design that re-enables after the first cause clears, and it checks that brown-out leaves the power sequence in place rather than restarting the soft start.

// File: rtl/drvsup_pkg.sv
package drvsup_pkg;
  typedef enum logic [1:0] {
    PWR_OFF  = 2'd0,
    PWR_RAMP = 2'd1,
    PWR_ON   = 2'd2,
    PWR_FALL = 2'd3
  } pwr_state_e;
endpackage

// File: rtl/drvsup_seq.sv
module drvsup_seq
  import drvsup_pkg::*;
#(
  parameter int T_UP = 34,
  parameter int T_DN = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic en_i,
  input  logic por_i,
  output logic pwr_on_o,
  output logic mute_o,
  output logic active_o
);
  localparam int MAXT = (T_UP > T_DN) ? T_UP : T_DN;
  localparam int CW   = $clog2(MAXT + 1);

  pwr_state_e      state_q;
  logic [CW-1:0]   cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= PWR_OFF;
      cnt_q   <= '0;
    end else if (por_i) begin
      state_q <= PWR_OFF;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        PWR_OFF: begin
          cnt_q <= '0;
          if (en_i) state_q <= PWR_RAMP;
        end
        PWR_RAMP: begin
          if (!en_i) begin
            state_q <= PWR_FALL;
            cnt_q   <= '0;
          end else if (tick_i) begin
            if (cnt_q == CW'(T_UP - 1)) begin
              state_q <= PWR_ON;
              cnt_q   <= '0;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        PWR_ON: begin
          if (!en_i) begin
            state_q <= PWR_FALL;
            cnt_q   <= '0;
          end
        end
        PWR_FALL: begin
          if (tick_i) begin
            if (cnt_q == CW'(T_DN - 1)) begin
              state_q <= PWR_OFF;
              cnt_q   <= '0;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        default: state_q <= PWR_OFF;
      endcase
    end
  end

  assign pwr_on_o = (state_q == PWR_ON);
  assign mute_o   = (state_q != PWR_ON);
  assign active_o = (state_q != PWR_OFF);
endmodule

// File: rtl/drvsup_therm.sv
module drvsup_therm #(
  parameter int T_COOL = 47
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic por_i,
  input  logic ot_i,
  input  logic cool_i,
  output logic hold_o
);
  localparam int CW = $clog2(T_COOL + 1);

  logic          hot_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hot_q <= 1'b0;
      cnt_q <= '0;
    end else if (por_i) begin
      hot_q <= 1'b0;
      cnt_q <= '0;
    end else if (ot_i) begin
      hot_q <= 1'b1;
      cnt_q <= '0;
    end else if (hot_q) begin
      if (!cool_i) begin
        cnt_q <= '0;
      end else if (tick_i) begin
        if (cnt_q == CW'(T_COOL - 1)) begin
          hot_q <= 1'b0;
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  // comparator cuts drivers before the flag registers
  assign hold_o = hot_q | ot_i;
endmodule

// File: rtl/drvsup_short.sv
module drvsup_short #(
  parameter int N_DRV  = 4,
  parameter int T_QUAL = 14,
  parameter int T_OFF  = 47
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             por_i,
  input  logic             arm_i,
  input  logic [N_DRV-1:0] oc_i,
  output logic             trip_o,
  output logic             off_o
);
  localparam int QW = $clog2(T_QUAL + 1);
  localparam int OW = $clog2(T_OFF + 1);

  logic          off_q;
  logic [QW-1:0] qcnt_q;
  logic [OW-1:0] ocnt_q;
  logic          oc_any;

  assign oc_any = |oc_i;
  assign trip_o = !off_q && arm_i && oc_any && tick_i &&
                  (qcnt_q == QW'(T_QUAL - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      off_q  <= 1'b0;
      qcnt_q <= '0;
      ocnt_q <= '0;
    end else if (por_i) begin
      off_q  <= 1'b0;
      qcnt_q <= '0;
      ocnt_q <= '0;
    end else if (off_q) begin
      qcnt_q <= '0;
      if (tick_i) begin
        if (ocnt_q == OW'(T_OFF - 1)) begin
          off_q  <= 1'b0;
          ocnt_q <= '0;
        end else begin
          ocnt_q <= ocnt_q + 1'b1;
        end
      end
    end else if (trip_o) begin
      off_q  <= 1'b1;
      qcnt_q <= '0;
      ocnt_q <= '0;
    end else if (arm_i && oc_any) begin
      if (tick_i) qcnt_q <= qcnt_q + 1'b1;
    end else begin
      qcnt_q <= '0;
    end
  end

  assign off_o = off_q;
endmodule

// File: rtl/drvsup_top.sv
module drvsup_top #(
  parameter int N_DRV     = 4,
  parameter int T_PWRUP   = 34,
  parameter int T_PWRDN   = 3,
  parameter int T_COOL    = 47,
  parameter int T_SC_QUAL = 14,
  parameter int T_SC_OFF  = 47
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             en_i,
  input  logic             por_i,
  input  logic             ot_i,
  input  logic             cool_i,
  input  logic [N_DRV-1:0] oc_i,
  input  logic             uv_i,
  output logic             drv_en_o,
  output logic             mute_o,
  output logic             active_o,
  output logic             flt_thermal_o,
  output logic             flt_short_o,
  output logic             flt_uv_o
);
  logic pwr_on, therm_hold, sc_trip, sc_off;
  logic flt_th_q, flt_sc_q, flt_uv_q;

  drvsup_seq #(.T_UP(T_PWRUP), .T_DN(T_PWRDN)) u_seq (
    .clk_i, .rst_ni, .tick_i, .en_i, .por_i,
    .pwr_on_o(pwr_on), .mute_o(mute_o), .active_o(active_o)
  );

  drvsup_therm #(.T_COOL(T_COOL)) u_therm (
    .clk_i, .rst_ni, .tick_i, .por_i, .ot_i, .cool_i,
    .hold_o(therm_hold)
  );

  drvsup_short #(.N_DRV(N_DRV), .T_QUAL(T_SC_QUAL), .T_OFF(T_SC_OFF)) u_short (
    .clk_i, .rst_ni, .tick_i, .por_i,
    .arm_i(pwr_on), .oc_i(oc_i),
    .trip_o(sc_trip), .off_o(sc_off)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flt_th_q <= 1'b0;
      flt_sc_q <= 1'b0;
      flt_uv_q <= 1'b0;
    end else if (por_i) begin
      flt_th_q <= 1'b0;
      flt_sc_q <= 1'b0;
      flt_uv_q <= 1'b0;
    end else begin
      if (ot_i)    flt_th_q <= 1'b1;
      if (sc_trip) flt_sc_q <= 1'b1;
      if (uv_i)    flt_uv_q <= 1'b1;
    end
  end

  assign drv_en_o      = pwr_on & ~therm_hold & ~sc_off & ~uv_i;
  assign flt_thermal_o = flt_th_q;
  assign flt_short_o   = flt_sc_q;
  assign flt_uv_o      = flt_uv_q;
endmodule

// File: rtl/drvsup_chk.sv
module drvsup_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic por_i,
  input logic ot_i,
  input logic uv_i,
  input logic drv_en_o,
  input logic mute_o,
  input logic active_o,
  input logic flt_thermal_o,
  input logic flt_short_o,
  input logic flt_uv_o
);
  p_por_clears_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    por_i |=> (!active_o && !flt_thermal_o && !flt_short_o && !flt_uv_o));

  p_rampup_muted_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(active_o) |-> mute_o);

  p_drv_needs_seq_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drv_en_o |-> (active_o && !mute_o));

  p_thermal_flag_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ot_i && !por_i) |=> flt_thermal_o);

  p_trip_cuts_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flt_short_o) |-> !drv_en_o);

  p_uv_flag_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (uv_i && !por_i) |=> flt_uv_o);

  p_short_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flt_short_o && !por_i) |=> flt_short_o);
endmodule

bind drvsup_top drvsup_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .por_i(por_i), .ot_i(ot_i), .uv_i(uv_i),
  .drv_en_o(drv_en_o), .mute_o(mute_o), .active_o(active_o),
  .flt_thermal_o(flt_thermal_o), .flt_short_o(flt_short_o), .flt_uv_o(flt_uv_o)
);

// File: tb/tb_drvsup_top.sv
module tb_drvsup_top;
  localparam int NDRV  = 2;
  localparam int PWRUP = 5;
  localparam int PWRDN = 3;
  localparam int COOL  = 6;
  localparam int SCQ   = 4;
  localparam int SCOFF = 7;
  localparam int WDOG  = 50000;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic tick_i = 1'b0, en_i = 1'b0, por_i = 1'b0, ot_i = 1'b0, cool_i = 1'b0, uv_i = 1'b0;
  logic [NDRV-1:0] oc_i = '0;
  logic drv_en_o, mute_o, active_o, flt_thermal_o, flt_short_o, flt_uv_o;

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;

  always #2 clk_i = ~clk_i;

  drvsup_top #(.N_DRV(NDRV), .T_PWRUP(PWRUP), .T_PWRDN(PWRDN), .T_COOL(COOL),
               .T_SC_QUAL(SCQ), .T_SC_OFF(SCOFF)) dut (
    .clk_i, .rst_ni, .tick_i, .en_i, .por_i, .ot_i, .cool_i, .oc_i, .uv_i,
    .drv_en_o, .mute_o, .active_o, .flt_thermal_o, .flt_short_o, .flt_uv_o
  );

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (cyc == WDOG) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  task automatic chk(string req, logic act, logic exp, string what);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  task automatic tick_n(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i) tick_i = 1'b1;
      @(negedge clk_i) tick_i = 1'b0;
    end
  endtask

  task automatic power_up();
    en_i = 1'b1;
    @(negedge clk_i);
    chk("R2", active_o, 1'b1, "active at ramp start");
    for (int k = 1; k < PWRUP; k++) begin
      tick_n(1);
      chk("R2", drv_en_o, 1'b0, "drv during ramp");
      chk("R2", mute_o, 1'b1, "mute during ramp");
    end
    tick_n(1);
    chk("R2", drv_en_o, 1'b1, "drv after ramp");
    chk("R2", mute_o, 1'b0, "mute after ramp");
  endtask

  task automatic do_por();
    @(negedge clk_i) por_i = 1'b1;
    @(negedge clk_i) por_i = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1", drv_en_o, 1'b0, "drv after reset");
    chk("R1", mute_o, 1'b1, "mute after reset");
    chk("R1", active_o, 1'b0, "active after reset");
    chk("R1", flt_thermal_o | flt_short_o | flt_uv_o, 1'b0, "flags after reset");

    power_up();

    // R3 power-down
    en_i = 1'b0;
    @(negedge clk_i);
    chk("R3", drv_en_o, 1'b0, "drv at power-down");
    chk("R3", mute_o, 1'b1, "mute at power-down");
    tick_n(PWRDN - 1);
    chk("R3", active_o, 1'b1, "active before window end");
    tick_n(1);
    chk("R3", active_o, 1'b0, "active after window");

    power_up();

    // R4/R5 thermal
    ot_i = 1'b1;
    #0 @(negedge clk_i);
    chk("R4", drv_en_o, 1'b0, "drv on over-temp");
    chk("R4", flt_thermal_o, 1'b1, "thermal flag");
    cool_i = 1'b1;
    tick_n(COOL + 2);
    chk("R5", drv_en_o, 1'b0, "no recovery while hot");
    ot_i = 1'b0;
    cool_i = 1'b0;
    tick_n(COOL + 2);
    chk("R5", drv_en_o, 1'b0, "no recovery while warm");
    for (int k = 1; k < COOL; k++) begin
      cool_i = 1'b1;
      tick_n(k);
      cool_i = 1'b0;
      @(negedge clk_i);
      chk("R5", drv_en_o, 1'b0, "broken cool window");
    end
    cool_i = 1'b1;
    tick_n(COOL - 1);
    chk("R5", drv_en_o, 1'b0, "cool window one short");
    tick_n(1);
    chk("R5", drv_en_o, 1'b1, "recovered after cool window");
    chk("R10", flt_thermal_o, 1'b1, "thermal flag sticky");

    // R6 short qualification sweep
    chk("R6", flt_short_o, 1'b0, "no short flag yet");
    for (int b = 0; b < NDRV; b++) begin
      for (int len = 1; len < SCQ; len++) begin
        oc_i = '0;
        oc_i[b] = 1'b1;
        tick_n(len);
        oc_i = '0;
        @(negedge clk_i);
        chk("R6", drv_en_o, 1'b1, "short pulse ignored");
      end
      oc_i[b] = 1'b1;
      tick_n(SCQ);
      oc_i = '0;
      chk("R6", drv_en_o, 1'b0, "trip on qualified short");
      chk("R6", flt_short_o, 1'b1, "short flag");
      tick_n(SCOFF - 1);
      chk("R7", drv_en_o, 1'b0, "off window holds");
      tick_n(1);
      chk("R7", drv_en_o, 1'b1, "retry after off window");
    end

    // R7 persistent short
    oc_i = '1;
    tick_n(SCQ);
    chk("R7", drv_en_o, 1'b0, "persistent trip");
    for (int r = 0; r < 3; r++) begin
      tick_n(SCOFF);
      chk("R7", drv_en_o, 1'b1, "retry enable");
      tick_n(SCQ - 1);
      chk("R7", drv_en_o, 1'b1, "requalifying");
      tick_n(1);
      chk("R7", drv_en_o, 1'b0, "re-trip");
    end
    oc_i = '0;
    tick_n(SCOFF);
    chk("R7", drv_en_o, 1'b1, "cleared short recovers");

    // R1 POR clears flags; R6 not armed while off
    en_i = 1'b0;
    do_por();
    chk("R1", active_o, 1'b0, "active after por");
    chk("R1", flt_thermal_o | flt_short_o | flt_uv_o, 1'b0, "flags after por");
    oc_i = '1;
    tick_n(SCQ + 3);
    oc_i = '0;
    @(negedge clk_i);
    chk("R6", flt_short_o, 1'b0, "no count while sequenced off");
    power_up();

    // R8 brown-out
    uv_i = 1'b1;
    #0 @(negedge clk_i);
    chk("R8", drv_en_o, 1'b0, "drv on undervoltage");
    chk("R8", active_o, 1'b1, "sequence kept");
    chk("R8", mute_o, 1'b0, "sequence still on");
    chk("R8", flt_uv_o, 1'b1, "uv flag");
    uv_i = 1'b0;
    @(negedge clk_i);
    chk("R8", drv_en_o, 1'b1, "immediate return after uv");
    chk("R10", flt_uv_o, 1'b1, "uv flag sticky");

    // R9 stacked faults
    ot_i = 1'b1;
    uv_i = 1'b1;
    cool_i = 1'b1;
    @(negedge clk_i);
    ot_i = 1'b0;
    tick_n(COOL);
    chk("R9", drv_en_o, 1'b0, "uv still holds");
    uv_i = 1'b0;
    @(negedge clk_i);
    chk("R9", drv_en_o, 1'b1, "all cleared");

    // R1 POR with en high then restart
    do_por();
    chk("R1", drv_en_o, 1'b0, "drv after por");
    chk("R1", active_o, 1'b0, "off right after por");
    chk("R10", flt_thermal_o | flt_uv_o, 1'b0, "por clears sticky flags");
    power_up();

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule